// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single requests from an on-chip master into read and write cycles on an asynchronous external memory bus shared by several devices, each with its own active-low chip select. Every device has its own set of timing fields. These fields set the wait cycles per access, an extra initial latency charged only when an access opens a new page, the number of cycles the chip select stays low after a write, and the idle turnaround cycles that let a device stop driving the data lines after a read.

The master presents a request with a write flag, a device index, an address and write data. The sequencer takes the request only when `req_ready` is high. It then runs the strobes and pulses `rsp_done` once the cycle is complete. For a read, the data sampled from the bus is returned with the same pulse. The sequencer tracks the page of the last read and the last write separately, and it adds turnaround only where a device that has just been read could still be driving the data lines.

Top module: `extbus_seq`

## Requirements
- R1: During and right after reset, every chip select, `mem_oe_n` and `mem_we_n` are high, `mem_dout_en` is low, `rsp_done` is low and `req_ready` is high. A reset that arrives in the middle of a cycle releases the strobes at once.
- R2: A read holds the addressed chip select and `mem_oe_n` low together for 1 + read-wait cycles, plus the read initial latency when the read opens a page. `mem_din` is sampled in the last of these cycles and appears on `rsp_rdata` while `rsp_done` is high in the following cycle.
- R3: A write holds the addressed chip select and `mem_we_n` low together for 1 + write-wait cycles, plus the write initial latency when the write opens a page. During that time `mem_addr` carries the request address, `mem_dout` carries the request data and `mem_dout_en` is high.
- R4: After `mem_we_n` rises, the chip select stays low for hold-field + 1 more cycles with `mem_dout` still driven. A hold field of 0 therefore gives one cycle and a hold field of 15 gives sixteen.
- R5: The page is `addr[ADDR_W-1:PAGE_BITS]`. A read opens a page when no read has happened since reset, or when its device index or page differs from those of the previous read. Writes are tracked the same way, separately from reads.
- R6: A read followed by a write, or by any access to a different device, first gets max(1, recovery field of the device just read) cycles with all strobes high and the data lines released. A field of 0 gives 1 cycle and a field of 15 gives 15.
- R7: A write followed by any access, and a read followed by a read of the same device, start their strobes in the cycle right after acceptance, with no recovery.
- R8: `req_ready` is low from the cycle after acceptance until the cycle in which `rsp_done` is high. `rsp_done` is high for exactly one cycle per request.
- R9: `mem_dout_en` is never high while `mem_oe_n` is low, during recovery, or while idle.
- R10: At most one chip select is low at any time, and it is the one whose index was given with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Device index |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_rd_wait | input | NUM_CS*WAIT_W | Per-device read wait cycles |
| cfg_wr_wait | input | NUM_CS*WAIT_W | Per-device write wait cycles |
| cfg_rd_init | input | NUM_CS*INIT_W | Per-device read page-open latency |
| cfg_wr_init | input | NUM_CS*INIT_W | Per-device write page-open latency |
| cfg_wr_hold | input | NUM_CS*HOLD_W | Per-device write hold field (cycles = field + 1) |
| cfg_recov | input | NUM_CS*REC_W | Per-device read turnaround field (cycles = max(1, field)) |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | DATA_W | External write data |
| mem_dout_en | output | 1 | Drive enable for the data lines |
| mem_din | input | DATA_W | External read data |
| mem_cs_n | output | NUM_CS | Active-low chip selects, bit i for device i |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_done` |

## Verification
The bench goes after the encodings that treat zero as one. A design that took the hold or recovery field literally would show no hold cycle after a write with field 0, and no gap after a read-to-write with field 0, so the device could still be driving the lines when the controller starts to drive them. Page tracking is checked for reads and writes separately, for a change of device with the page unchanged, and again after a reset in mid-sequence. A tracker shared between reads and writes, or one that survives reset, charges the initial latency at the wrong times and gives visibly wrong strobe widths. The long cases (255 latency plus 15 wait, hold 15, recovery 15) are there to expose a counter that is too narrow. A turnaround inserted after writes, or after reads of the same device, shows up as a gap that the bench does not expect.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RECOV  = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_HOLD   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/extbus_field_mux.sv
module extbus_field_mux #(
   parameter int FW    = 4,
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N*FW-1:0] flat,
   input  logic [IDX_W-1:0] idx,
   output logic [FW-1:0]   field
);
   always_comb begin
      field = '0;
      for (int i = 0; i < N; i++) begin
         if (idx == IDX_W'(i)) field = flat[i*FW +: FW];
      end
   end
endmodule

// File: rtl/extbus_page_track.sv
module extbus_page_track #(
   parameter int CS_W = 2,
   parameter int PG_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd,
   input  logic [CS_W-1:0] cs,
   input  logic [PG_W-1:0] page,
   output logic            first
);
   logic            vld_q;
   logic [CS_W-1:0] cs_q;
   logic [PG_W-1:0] page_q;

   assign first = !vld_q || (cs != cs_q) || (page != page_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         cs_q   <= '0;
         page_q <= '0;
      end else if (upd) begin
         vld_q  <= 1'b1;
         cs_q   <= cs;
         page_q <= page;
      end
   end
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
   import extbus_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int PAGE_BITS = 4,
   parameter int WAIT_W    = 4,
   parameter int INIT_W    = 8,
   parameter int HOLD_W    = 4,
   parameter int REC_W     = 4,
   localparam int CS_W     = $clog2(NUM_CS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [CS_W-1:0]          req_cs,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic [NUM_CS*WAIT_W-1:0] cfg_rd_wait,
   input  logic [NUM_CS*WAIT_W-1:0] cfg_wr_wait,
   input  logic [NUM_CS*INIT_W-1:0] cfg_rd_init,
   input  logic [NUM_CS*INIT_W-1:0] cfg_wr_init,
   input  logic [NUM_CS*HOLD_W-1:0] cfg_wr_hold,
   input  logic [NUM_CS*REC_W-1:0]  cfg_recov,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]        mem_dout,
   output logic                     mem_dout_en,
   input  logic [DATA_W-1:0]        mem_din,
   output logic [NUM_CS-1:0]        mem_cs_n,
   output logic                     mem_oe_n,
   output logic                     mem_we_n,
   output logic                     rsp_done,
   output logic [DATA_W-1:0]        rsp_rdata
);
   localparam int PG_W    = ADDR_W - PAGE_BITS;
   localparam int LEN_MAX = (1 << WAIT_W) + (1 << INIT_W) - 1;
   localparam int CNT_W   = $clog2(LEN_MAX + 1);

   generate
      if (NUM_CS < 2)             $error("NUM_CS must be at least 2");
      if (PAGE_BITS >= ADDR_W)    $error("PAGE_BITS must be below ADDR_W");
      if (HOLD_W >= CNT_W)        $error("HOLD_W too wide for counter");
      if (REC_W >= CNT_W)         $error("REC_W too wide for counter");
   endgenerate

   seq_state_e          state;
   logic [CNT_W-1:0]    cnt;
   logic                wr_q, last_rd_q, done_q;
   logic [CS_W-1:0]     cs_q, last_cs_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q, rdata_q;
   logic [CNT_W-1:0]    act_load_q;
   logic [HOLD_W-1:0]   hold_q;

   // per-device field selection
   logic [WAIT_W-1:0] rd_wait_f, wr_wait_f;
   logic [INIT_W-1:0] rd_init_f, wr_init_f;
   logic [HOLD_W-1:0] hold_f;
   logic [REC_W-1:0]  rec_f;

   extbus_field_mux #(.FW(WAIT_W), .N(NUM_CS), .IDX_W(CS_W)) u_mux_rdw
      (.flat(cfg_rd_wait), .idx(req_cs), .field(rd_wait_f));
   extbus_field_mux #(.FW(WAIT_W), .N(NUM_CS), .IDX_W(CS_W)) u_mux_wrw
      (.flat(cfg_wr_wait), .idx(req_cs), .field(wr_wait_f));
   extbus_field_mux #(.FW(INIT_W), .N(NUM_CS), .IDX_W(CS_W)) u_mux_rdi
      (.flat(cfg_rd_init), .idx(req_cs), .field(rd_init_f));
   extbus_field_mux #(.FW(INIT_W), .N(NUM_CS), .IDX_W(CS_W)) u_mux_wri
      (.flat(cfg_wr_init), .idx(req_cs), .field(wr_init_f));
   extbus_field_mux #(.FW(HOLD_W), .N(NUM_CS), .IDX_W(CS_W)) u_mux_hld
      (.flat(cfg_wr_hold), .idx(req_cs), .field(hold_f));
   extbus_field_mux #(.FW(REC_W), .N(NUM_CS), .IDX_W(CS_W)) u_mux_rec
      (.flat(cfg_recov), .idx(last_cs_q), .field(rec_f));

   // page-open trackers: index 0 for reads, 1 for writes
   logic       accept;
   logic [1:0] first_v;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   generate
      for (genvar k = 0; k < 2; k++) begin : g_trk
         logic upd;
         assign upd = accept && (req_write == (k == 1));
         extbus_page_track #(.CS_W(CS_W), .PG_W(PG_W)) u_trk (
            .clk(clk), .rst_n(rst_n), .upd(upd), .cs(req_cs),
            .page(req_addr[ADDR_W-1:PAGE_BITS]), .first(first_v[k]));
      end
   endgenerate

   logic             need_rec, is_first;
   logic [CNT_W-1:0] act_load, rec_load;

   always_comb begin
      is_first = req_write ? first_v[1] : first_v[0];
      act_load = req_write ? CNT_W'(wr_wait_f) : CNT_W'(rd_wait_f);
      if (is_first)
         act_load = act_load + (req_write ? CNT_W'(wr_init_f) : CNT_W'(rd_init_f));
      need_rec = last_rd_q && (req_write || (req_cs != last_cs_q));
      rec_load = (rec_f == '0) ? '0 : CNT_W'(rec_f - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         wr_q       <= 1'b0;
         cs_q       <= '0;
         addr_q     <= '0;
         wdata_q    <= '0;
         rdata_q    <= '0;
         act_load_q <= '0;
         hold_q     <= '0;
         last_rd_q  <= 1'b0;
         last_cs_q  <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               wr_q       <= req_write;
               cs_q       <= req_cs;
               addr_q     <= req_addr;
               wdata_q    <= req_wdata;
               act_load_q <= act_load;
               hold_q     <= hold_f;
               last_rd_q  <= !req_write;
               last_cs_q  <= req_cs;
               if (need_rec) begin
                  state <= ST_RECOV;
                  cnt   <= rec_load;
               end else begin
                  state <= ST_ACTIVE;
                  cnt   <= act_load;
               end
            end
            ST_RECOV: begin
               if (cnt == '0) begin
                  state <= ST_ACTIVE;
                  cnt   <= act_load_q;
               end else cnt <= cnt - 1'b1;
            end
            ST_ACTIVE: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else if (wr_q) begin
                  state <= ST_HOLD;
                  cnt   <= CNT_W'(hold_q);
               end else begin
                  rdata_q <= mem_din;
                  done_q  <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            ST_HOLD: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic cs_on;
   assign cs_on       = (state == ST_ACTIVE) || (state == ST_HOLD);
   assign mem_oe_n    = !((state == ST_ACTIVE) && !wr_q);
   assign mem_we_n    = !((state == ST_ACTIVE) && wr_q);
   assign mem_dout_en = cs_on && wr_q;
   assign mem_dout    = wdata_q;
   assign mem_addr    = addr_q;
   assign rsp_done    = done_q;
   assign rsp_rdata   = rdata_q;

   generate
      for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
         assign mem_cs_n[c] = !(cs_on && (cs_q == CS_W'(c)));
      end
   endgenerate
endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_done,
   input logic [NUM_CS-1:0] mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dout_en
);
   assert_no_drive_on_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dout_en);
   assert_cs_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~mem_cs_n) <= 1);
   assert_oe_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (~mem_cs_n != '0));
   assert_oe_we_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));
   assert_we_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> ((~mem_cs_n != '0) && mem_dout_en));
   assert_hold_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ((~mem_cs_n != '0) && mem_dout_en));
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   assert_idle_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs_n == '1) |-> !mem_dout_en);
endmodule

bind extbus_seq extbus_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_done(rsp_done), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
   .mem_we_n(mem_we_n), .mem_dout_en(mem_dout_en));

// File: tb/sim_extbus_seq.sv
module sim_extbus_seq;
   localparam int NCS = 4;
   localparam int AW  = 16;
   localparam int DW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [1:0] req_cs = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, mem_dout_en, mem_oe_n, mem_we_n, rsp_done;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout, mem_din, rsp_rdata;
   logic [NCS-1:0] mem_cs_n;

   logic [3:0] rdw[NCS], wrw[NCS], hld[NCS], rcv[NCS];
   logic [7:0] rdi[NCS], wri[NCS];
   logic [NCS*4-1:0] f_rdw, f_wrw, f_hld, f_rcv;
   logic [NCS*8-1:0] f_rdi, f_wri;

   always_comb begin
      for (int c = 0; c < NCS; c++) begin
         f_rdw[c*4 +: 4] = rdw[c];
         f_wrw[c*4 +: 4] = wrw[c];
         f_hld[c*4 +: 4] = hld[c];
         f_rcv[c*4 +: 4] = rcv[c];
         f_rdi[c*8 +: 8] = rdi[c];
         f_wri[c*8 +: 8] = wri[c];
      end
   end

   assign mem_din = mem_addr ^ 16'h5A5A;

   always #10 clk = ~clk;

   extbus_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_rd_wait(f_rdw), .cfg_wr_wait(f_wrw), .cfg_rd_init(f_rdi), .cfg_wr_init(f_wri),
      .cfg_wr_hold(f_hld), .cfg_recov(f_rcv), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_cs_n(mem_cs_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata));

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic        wr;
      logic [1:0]  cs;
      logic [15:0] addr;
      logic [15:0] data;
      logic        first;
      logic        rec;
      logic [1:0]  prev;
   } vec_t;

   localparam vec_t VEC[15] = '{
      '{1'b1, 2'd0, 16'h0010, 16'h1111, 1'b1, 1'b0, 2'd0},
      '{1'b1, 2'd0, 16'h0012, 16'h2222, 1'b0, 1'b0, 2'd0},
      '{1'b0, 2'd0, 16'h0010, 16'h0000, 1'b1, 1'b0, 2'd0},
      '{1'b0, 2'd0, 16'h0015, 16'h0000, 1'b0, 1'b0, 2'd0},
      '{1'b0, 2'd0, 16'h0025, 16'h0000, 1'b1, 1'b0, 2'd0},
      '{1'b1, 2'd0, 16'h0025, 16'h3333, 1'b1, 1'b1, 2'd0},
      '{1'b0, 2'd1, 16'h0100, 16'h0000, 1'b1, 1'b0, 2'd0},
      '{1'b0, 2'd3, 16'h0100, 16'h0000, 1'b1, 1'b1, 2'd1},
      '{1'b1, 2'd1, 16'h0040, 16'h4444, 1'b1, 1'b1, 2'd3},
      '{1'b1, 2'd1, 16'h0041, 16'h5555, 1'b0, 1'b0, 2'd1},
      '{1'b0, 2'd2, 16'h0000, 16'h0000, 1'b1, 1'b0, 2'd1},
      '{1'b0, 2'd2, 16'h0003, 16'h0000, 1'b0, 1'b0, 2'd2},
      '{1'b1, 2'd2, 16'h0003, 16'h6666, 1'b1, 1'b1, 2'd2},
      '{1'b0, 2'd3, 16'h0100, 16'h0000, 1'b1, 1'b0, 2'd2},
      '{1'b0, 2'd3, 16'h0101, 16'h0000, 1'b0, 1'b0, 2'd3}
   };

   task automatic run(input vec_t v, input string tag);
      int exp_act, exp_gap, exp_hold;
      int gap, act, hold, bad_drv, bad_cs, busy_rdy, cyc, addr_ok;
      logic [NCS-1:0] exp_mask;
      exp_act  = 1 + (v.wr ? int'(wrw[v.cs]) : int'(rdw[v.cs]));
      if (v.first) exp_act += v.wr ? int'(wri[v.cs]) : int'(rdi[v.cs]);
      exp_gap  = !v.rec ? 0 : ((rcv[v.prev] == 0) ? 1 : int'(rcv[v.prev]));
      exp_hold = v.wr ? int'(hld[v.cs]) + 1 : 0;
      exp_mask = ~(NCS'(1) << v.cs);
      @(negedge clk);
      chk(req_ready == 1'b1, {"R8 ready idle ", tag}, int'(req_ready), 1);
      req_valid = 1'b1; req_write = v.wr; req_cs = v.cs;
      req_addr = v.addr; req_wdata = v.data;
      @(negedge clk);
      req_valid = 1'b0;
      gap = 0; act = 0; hold = 0; bad_drv = 0; bad_cs = 0; busy_rdy = 0; cyc = 0; addr_ok = 1;
      while (!rsp_done && cyc < 2000) begin
         if (req_ready) busy_rdy++;
         if (mem_cs_n == '1) begin
            if (act == 0) gap++;
            if (mem_dout_en) bad_drv++;
         end else begin
            if (mem_cs_n != exp_mask) bad_cs++;
            if (!mem_oe_n && mem_dout_en) bad_drv++;
            if (v.wr && !mem_dout_en) bad_drv++;
            if (v.wr ? !mem_we_n : !mem_oe_n) begin
               act++;
               if (mem_addr != v.addr) addr_ok = 0;
               if (v.wr && mem_dout != v.data) addr_ok = 0;
            end else if (v.wr) hold++;
         end
         @(negedge clk);
         cyc++;
      end
      chk(rsp_done == 1'b1, {"R8 done seen ", tag}, int'(rsp_done), 1);
      chk(gap == exp_gap, {v.rec ? "R6 recovery gap " : "R7 no gap ", tag}, gap, exp_gap);
      chk(act == exp_act, {v.wr ? "R3 R5 we width " : "R2 R5 oe width ", tag}, act, exp_act);
      chk(addr_ok == 1, {"R3 addr/data on bus ", tag}, addr_ok, 1);
      chk(bad_drv == 0, {"R9 drive ", tag}, bad_drv, 0);
      chk(bad_cs == 0, {"R10 cs select ", tag}, bad_cs, 0);
      chk(busy_rdy == 0, {"R8 ready busy ", tag}, busy_rdy, 0);
      chk(req_ready == 1'b1, {"R8 ready at done ", tag}, int'(req_ready), 1);
      if (v.wr) chk(hold == exp_hold, {"R4 hold ", tag}, hold, exp_hold);
      else chk(rsp_rdata == (v.addr ^ 16'h5A5A), {"R2 rdata ", tag},
               int'(rsp_rdata), int'(v.addr ^ 16'h5A5A));
      @(negedge clk);
      chk(rsp_done == 1'b0, {"R8 done pulse ", tag}, int'(rsp_done), 0);
   endtask

   task automatic chk_reset(input string tag);
      chk(mem_cs_n == '1, {"R1 cs_n ", tag}, int'(mem_cs_n), 15);
      chk(mem_oe_n && mem_we_n, {"R1 oe/we ", tag}, int'({mem_oe_n, mem_we_n}), 3);
      chk(!mem_dout_en && !rsp_done, {"R1 drive/done ", tag},
          int'({mem_dout_en, rsp_done}), 0);
      chk(req_ready == 1'b1, {"R1 ready ", tag}, int'(req_ready), 1);
   endtask

   initial begin
      rdw = '{4'd2, 4'd0, 4'd15, 4'd1};
      wrw = '{4'd1, 4'd0, 4'd15, 4'd3};
      rdi = '{8'd3, 8'd0, 8'd255, 8'd1};
      wri = '{8'd2, 8'd5, 8'd255, 8'd0};
      hld = '{4'd0, 4'd2, 4'd15, 4'd1};
      rcv = '{4'd0, 4'd3, 4'd15, 4'd2};
      repeat (3) @(negedge clk);
      chk_reset("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset("after release");

      for (int i = 0; i < 15; i++) run(VEC[i], $sformatf("vec%0d", i));

      // reset in the middle of a long read on device 2
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_cs = 2'd2; req_addr = 16'h0800;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(mem_oe_n == 1'b0, "R2 busy before reset", int'(mem_oe_n), 0);
      rst_n = 1'b0;
      #1;
      chk_reset("mid-cycle");
      @(negedge clk);
      rst_n = 1'b1;

      // trackers and turnaround state cleared by reset
      run('{1'b1, 2'd0, 16'h0012, 16'h7777, 1'b1, 1'b0, 2'd0}, "post-reset write");
      run('{1'b0, 2'd0, 16'h0012, 16'h0000, 1'b1, 1'b0, 2'd0}, "post-reset read");
      // same page, other device: page opens and zero recovery field gives 1
      run('{1'b0, 2'd1, 16'h0012, 16'h0000, 1'b1, 1'b1, 2'd0}, "cs change same page");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule